// File: doc/BRIEF.md
# Programmable Periodic Event Generator

This block turns a slow timebase tick of 32.768 kHz into a programmable periodic event. A 4-bit rate code selects a period that is a power of two of timebase ticks. The block keeps a free-running tick counter, and an event fires on the ticks where that counter is a whole multiple of the selected period. An event therefore lands on a fixed grid of ticks. It does not fall a set delay after the configuration changes. Codes 1 and 2 are too fast to be useful, so they map onto the slower codes 8 and 9. Code 0 switches events off.

The generator runs only while at least one of its two enables is set. On each event, the interrupt enable produces a single-clock strobe on `flag_set_o`. The consumer uses this strobe to set its periodic flag and its interrupt request flag together. On each event, the square-wave enable raises `sqw_pulse_o` for exactly one timebase tick. The rate code and the enables are sampled on every clock, so a change applies from the next tick.

Control is a three-state machine: `ST_IDLE` (generator inactive), `ST_WAIT` (active, pulse low) and `ST_PULSE` (pulse high). Its transitions are as follows:
- **arm**: `ST_IDLE` to `ST_WAIT` when the block becomes active.
- **disarm**: `ST_WAIT` to `ST_IDLE` when it becomes inactive.
- **fire**: any state to `ST_PULSE` on an event with the square-wave enable set.
- **expire**: `ST_PULSE` to `ST_WAIT` or `ST_IDLE` on the next tick, or at once when the square-wave enable drops.
- **hold**: every other case keeps the current state.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset both outputs are low and the tick counter is zero, so with the block active the first tick after reset is an event.
- R2: For rate codes 3 to 15 an event occurs on a tick whose counter value, before it advances, has its low (code-1) bits all zero, giving a period of 2^(code-1) ticks.
- R3: Rate code 1 behaves exactly as code 8 (period 128 ticks) and code 2 exactly as code 9 (period 256 ticks).
- R4: Rate code 0 produces no event on either output.
- R5: With both enables low, no event appears on either output, whatever the rate code.
- R6: `flag_set_o` is high for exactly one clock, in the clock cycle after the event tick is sampled, and only when the interrupt enable is set at that tick.
- R7: `sqw_pulse_o` rises in the clock cycle after the event tick and falls in the clock cycle after the next tick, and only when the square-wave enable is set.
- R8: Enabling the block part-way through a period places the first event on the next counter multiple, not one full period after the enable.
- R9: A new rate code or enable setting applies from the next tick, with no wait for a period to finish.
- R10: The tick counter advances by one on every tick, whether the block is active or not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock strobe per 32.768 kHz timebase tick |
| rate_code_i | input | 4 | Period select; 0 off, 1 and 2 alias to 8 and 9 |
| pie_en_i | input | 1 | Periodic interrupt enable |
| sqw_en_i | input | 1 | Square-wave pulse enable |
| flag_set_o | output | 1 | One-clock strobe telling the consumer to set its periodic and interrupt request flags |
| sqw_pulse_o | output | 1 | Pulse one timebase tick long on each event |

## Verification
The bench targets the following corner cases:
- **Aliased codes 1 and 2.** A design that used the raw value would fire every tick or every other tick instead of every 128 or 256 ticks.
- **Mid-period enable.** A design that restarted its count at enable time would deliver the first event one full period late.
- **Reset in the middle of a run.** A counter that did not clear would misplace the first event after reset.
- **Rate changes between runs and code 0.** These expose any period that is latched at enable time.
- **Pulse width.** The bench checks that the pulse ends on the very next tick rather than stretching to the following one.

// File: rtl/pig_pkg.sv
package pig_pkg;
    localparam int CNT_W     = 15;  // free-running tick counter width
    localparam int RATE_W    = 4;   // rate code width
    localparam int ALIAS_MAX = 2;   // highest code that is remapped
    localparam int ALIAS_ADD = 7;   // offset added to remapped codes

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2
    } pig_state_e;
endpackage

// File: rtl/pig_timebase.sv
module pig_timebase #(
    parameter int CW = pig_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    output logic [CW-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_o <= '0;
        else if (tick_i)
            count_o <= count_o + 1'b1;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> count_o == $past(count_o) + 1'b1)
        else $error("counter did not step on tick"); // R10
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_o))
        else $error("counter moved without tick"); // R10
endmodule

// File: rtl/pig_rate_decode.sv
module pig_rate_decode #(
    parameter int CW = pig_pkg::CNT_W,
    parameter int RW = pig_pkg::RATE_W
) (
    input  logic [RW-1:0] rate_code_i,
    input  logic [CW-1:0] count_i,
    output logic          code_ok_o,
    output logic          aligned_o
);
    localparam logic [RW-1:0] AMAX = RW'(pig_pkg::ALIAS_MAX);
    localparam logic [RW-1:0] AADD = RW'(pig_pkg::ALIAS_ADD);

    logic [RW-1:0] eff_code;
    logic [RW-1:0] shift_amt;
    logic [CW-1:0] low_mask;

    always_comb begin
        if (rate_code_i != '0 && rate_code_i <= AMAX)
            eff_code = rate_code_i + AADD;
        else
            eff_code = rate_code_i;
        shift_amt = (eff_code == '0) ? '0 : eff_code - 1'b1;
    end

    for (genvar b = 0; b < CW; b++) begin : g_mask
        assign low_mask[b] = (32'(shift_amt) > b);
    end

    assign code_ok_o = (rate_code_i != '0);
    assign aligned_o = ((count_i & low_mask) == '0);
endmodule

// File: rtl/pig_fsm.sv
module pig_fsm
    import pig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic code_ok_i,
    input  logic aligned_i,
    input  logic pie_en_i,
    input  logic sqw_en_i,
    output logic flag_set_o,
    output logic sqw_pulse_o
);
    pig_state_e state, nxt;
    logic active, evt;

    assign active = code_ok_i && (pie_en_i || sqw_en_i);
    assign evt    = tick_i && active && aligned_i;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (evt && sqw_en_i)  nxt = ST_PULSE;   // fire
                else if (active)      nxt = ST_WAIT;    // arm
            end
            ST_WAIT: begin
                if (evt && sqw_en_i)  nxt = ST_PULSE;   // fire
                else if (!active)     nxt = ST_IDLE;    // disarm
            end
            ST_PULSE: begin
                if (evt && sqw_en_i)          nxt = ST_PULSE;                    // fire
                else if (tick_i || !sqw_en_i) nxt = active ? ST_WAIT : ST_IDLE;  // expire
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_set_o <= 1'b0;
        else        flag_set_o <= evt && pie_en_i;
    end

    assign sqw_pulse_o = (state == ST_PULSE);

    AST_FLAG_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set_o |=> !flag_set_o)
        else $error("flag strobe longer than one clock"); // R6
    AST_FLAG_NEEDS_PIE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_set_o) |-> $past(pie_en_i) && $past(tick_i))
        else $error("flag strobe without enable and tick"); // R6
    AST_PULSE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE && tick_i) |=> state != ST_PULSE)
        else $error("pulse outlived its tick"); // R7
    AST_PULSE_NEEDS_SQW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sqw_pulse_o) |-> $past(sqw_en_i))
        else $error("pulse without square-wave enable"); // R7
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
    parameter int CW = pig_pkg::CNT_W,
    parameter int RW = pig_pkg::RATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [RW-1:0] rate_code_i,
    input  logic          pie_en_i,
    input  logic          sqw_en_i,
    output logic          flag_set_o,
    output logic          sqw_pulse_o
);
    logic [CW-1:0] count;
    logic          code_ok, aligned;

    pig_timebase #(.CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .count_o(count)
    );

    pig_rate_decode #(.CW(CW), .RW(RW)) u_dec (
        .rate_code_i(rate_code_i), .count_i(count),
        .code_ok_o(code_ok), .aligned_o(aligned)
    );

    pig_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .code_ok_i(code_ok), .aligned_i(aligned),
        .pie_en_i(pie_en_i), .sqw_en_i(sqw_en_i),
        .flag_set_o(flag_set_o), .sqw_pulse_o(sqw_pulse_o)
    );

    AST_CODE0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && rate_code_i == '0) |=> !flag_set_o && !$rose(sqw_pulse_o))
        else $error("event with rate code zero"); // R4
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pie_en_i && !sqw_en_i) |=> !flag_set_o && !$rose(sqw_pulse_o))
        else $error("event with both enables low"); // R5
endmodule

// File: tb/periodic_irq_gen_tb_top.sv
module periodic_irq_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] code = 4'd0;
    logic       pie = 1'b0, sqw = 1'b0;
    logic       flag_o, pulse_o;

    int tests = 0, fails = 0;
    int tb_cnt = 0;
    bit exp_sqw = 0;

    always #10 clk = ~clk;  // 50 MHz

    periodic_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rate_code_i(code),
        .pie_en_i(pie), .sqw_en_i(sqw),
        .flag_set_o(flag_o), .sqw_pulse_o(pulse_o)
    );

    // code, pie, sqw, number of ticks
    typedef struct packed { logic [3:0] c; logic p; logic s; logic [10:0] n; } vec_t;
    localparam vec_t VECS [9] = '{
        '{4'd3, 1'b1, 1'b0, 11'd16},   // R2 period 4
        '{4'd4, 1'b1, 1'b1, 11'd24},   // R2 R7 period 8
        '{4'd0, 1'b1, 1'b1, 11'd20},   // R4
        '{4'd5, 1'b0, 1'b0, 11'd40},   // R5
        '{4'd6, 1'b0, 1'b1, 11'd64},   // R7 pulse only
        '{4'd1, 1'b1, 1'b0, 11'd260},  // R3 alias to 8
        '{4'd2, 1'b1, 1'b1, 11'd520},  // R3 alias to 9
        '{4'd7, 1'b1, 1'b0, 11'd70},   // R9 rate change
        '{4'd3, 1'b1, 1'b1, 11'd9}     // R9 rate change
    };

    function automatic int period_of(input logic [3:0] c);
        int e = (c == 4'd1 || c == 4'd2) ? int'(c) + 7 : int'(c);
        return 1 << (e - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (tick count %0d)", req, act, exp, tb_cnt);
        end
    endtask

    // one tick plus two idle clocks; reports whether the flag strobe appeared
    task automatic do_tick(output bit got_flag);
        bit evt;
        evt = (code != 0) && (pie || sqw) && ((tb_cnt % period_of(code)) == 0);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        tb_cnt++;
        exp_sqw = evt && sqw;
        got_flag = flag_o;
        chk(flag_o == (evt && pie), "R6 flag at tick", int'(flag_o), int'(evt && pie));
        chk(pulse_o == exp_sqw, "R7 pulse at tick", int'(pulse_o), int'(exp_sqw));
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(flag_o == 1'b0, "R6 flag single clock", int'(flag_o), 0);
            chk(pulse_o == exp_sqw, "R7 pulse held", int'(pulse_o), int'(exp_sqw));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit f;
        int n;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(flag_o == 0 && pulse_o == 0, "R1 reset outputs", int'({flag_o, pulse_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk (R2 R3 R4 R5 R7 R9 R10 via continuous alignment)
        foreach (VECS[k]) begin
            @(negedge clk);
            code = VECS[k].c; pie = VECS[k].p; sqw = VECS[k].s;
            for (int t = 0; t < int'(VECS[k].n); t++) do_tick(f);
        end

        // R8: enable in the middle of a period (code 5, period 16)
        @(negedge clk);
        code = 4'd5; pie = 1'b0; sqw = 1'b0;
        while ((tb_cnt % 16) != 5) do_tick(f);
        @(negedge clk) pie = 1'b1;
        n = 0; f = 0;
        while (!f && n < 40) begin do_tick(f); n++; end
        chk(n == 12, "R8 first event on next multiple", n, 12);

        // R1: reset in mid-run clears the counter
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk(flag_o == 0 && pulse_o == 0, "R1 mid-run reset outputs", int'({flag_o, pulse_o}), 0);
        tb_cnt = 0; exp_sqw = 0;
        code = 4'd4; pie = 1'b1; sqw = 1'b1;
        @(negedge clk) rst_n = 1'b1;
        do_tick(f);
        chk(f == 1'b1, "R1 first tick after reset fires", int'(f), 1);
        for (int t = 0; t < 10; t++) do_tick(f);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule